// File: doc/BRIEF.md
# CAN Receive Frame Parser with Identifier Acceptance

This block sits above a CAN bit layer that has already handled bit timing and stuff-bit removal. It is told that a frame has started by a one-cycle start pulse, and then it receives the frame one bit at a time as a bit value qualified by a valid strobe. From this stream it works out the identifier, the format bit, the remote bit, the length code, the payload and the CRC. From the format bit it decides whether the identifier is 11 or 29 bits long.

Each frame is checked against one of two wildcard filters: one for 11-bit identifiers and one for 29-bit identifiers. A remote frame is also compared with a fixed local identifier. The block requests a dominant ACK only for a frame that meets all of these conditions: its CRC is intact, its CRC delimiter is recessive, and it is accepted. When the ACK slot bit arrives for an accepted data frame, the stored payload is released as a burst of one byte per clock, with a marker on the final byte. The consumer has no way to stall this burst. When the ACK slot bit arrives for a remote frame addressed to the local identifier, a one-cycle reply request is raised instead.

Top module: `can_rx_parser`

## Requirements
- R1: While reset is asserted and in the first cycle after it, ack_req, rx_vld, rx_last and remote_req are all 0.
- R2: An 11-bit identifier passes when ((id ^ SHORT_FILT) & SHORT_MASK) == 0. A mask bit of 1 must match the filter and a mask bit of 0 is ignored. With filter 0x122 and mask 0x17E, the identifiers 0x123 and 0x1A2 pass and 0x124 fails.
- R3: A 29-bit identifier passes by the same rule using LONG_FILT and LONG_MASK. The 11 base bits, received first, form bits [28:18] and the 18 extension bits form bits [17:0].
- R4: A data frame whose identifier fails its filter gives no ack_req and no rx_vld.
- R5: An accepted data frame with n bytes drives rx_vld for n consecutive cycles. These start in the cycle after the ACK-slot bit strobe. The bytes come out in the order they were received, and rx_last is 1 only on the final byte.
- R6: rx_id and rx_ext stay constant for the whole burst. rx_ext is 1 for a 29-bit identifier. An 11-bit identifier appears in rx_id[10:0] with the upper bits 0.
- R7: A remote frame with an 11-bit identifier equal to LOCAL_ID is acknowledged and raises remote_req for exactly one cycle, after the ACK-slot strobe, with no byte burst. A remote frame with any other identifier gets neither ack_req nor remote_req.
- R8: The CRC uses generator 0x4599 and covers every bit from the start bit (dominant) through the payload. A frame whose received 15-bit CRC does not match gets no ack_req and no output.
- R9: A length code above 8 is treated as 8 payload bytes.
- R10: ack_req rises in the cycle after a recessive CRC-delimiter strobe and falls in the cycle after the ACK-slot strobe. If the CRC delimiter is dominant, there is no ack_req.
- R11: An accepted data frame with length code 0 is acknowledged but produces no rx_vld.
- R12: A start pulse in the middle of a frame abandons that frame, and parsing restarts at the identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-frame pulse, one cycle |
| bit_vld | input | 1 | Strobe marking a received destuffed bit |
| bit_val | input | 1 | Received bit value (1 = recessive) |
| ack_req | output | 1 | Request to drive a dominant ACK slot |
| rx_vld | output | 1 | Payload byte valid |
| rx_last | output | 1 | Final byte of the burst |
| rx_byte | output | 8 | Payload byte |
| rx_id | output | 29 | Identifier of the frame being replayed |
| rx_ext | output | 1 | 1 = 29-bit identifier |
| remote_req | output | 1 | One-cycle request to answer a local remote frame |

## Verification
The test frames are built to probe specific behaviours:
- Identifiers placed just inside and just outside each filter show that masked bits are ignored and unmasked bits are enforced, for both identifier widths.
- Remote frames to the local identifier and to a foreign identifier separate the reply path from the data path.
- Length codes of 0, 1, 4, 8 and 15 show how the burst length is clipped and where the last marker falls.
- A single flipped CRC bit, a dominant CRC delimiter, and a frame cut off by a fresh start pulse show that the ACK and the output are withheld, or that the parser recovers.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;
  localparam int SID_W   = 11;
  localparam int XID_W   = 18;
  localparam int EID_W   = SID_W + XID_W;
  localparam int CRC_W   = 15;
  localparam int DLC_W   = 4;
  localparam int BYTE_W  = 8;
  localparam int MAX_BYTES = 8;
  localparam int DATA_W  = MAX_BYTES * BYTE_W;
  localparam int CNT_W   = $clog2(DATA_W) + 1;
  localparam logic [CRC_W-1:0] CRC_GEN = 15'h4599;

  typedef enum logic [3:0] {
    ST_IDLE, ST_BASE_ID, ST_B12, ST_IDE, ST_EXT_ID, ST_RTR, ST_R1, ST_R0,
    ST_DLC, ST_DATA, ST_CRC, ST_CRC_DEL, ST_ACK
  } rx_state_e;

  // one serial step of the CRC register
  function automatic logic [CRC_W-1:0] crc_step(logic [CRC_W-1:0] c, logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_GEN : '0);
  endfunction

  // payload bytes for a length code, clipped to the maximum
  function automatic logic [DLC_W-1:0] dlc_bytes(logic [DLC_W-1:0] dlc);
    return (dlc > DLC_W'(MAX_BYTES)) ? DLC_W'(MAX_BYTES) : dlc;
  endfunction
endpackage

// File: rtl/can_rx_crc.sv
module can_rx_crc
  import can_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic bit_in,
  output logic crc_zero
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   crc_q <= '0;
    else if (clr) crc_q <= '0;
    else if (en)  crc_q <= crc_step(crc_q, bit_in);
  end

  // feeding the received CRC through the register leaves zero when it matches
  assign crc_zero = (crc_q == '0);
endmodule

// File: rtl/can_rx_filter.sv
module can_rx_filter
  import can_rx_pkg::*;
#(
  parameter logic [SID_W-1:0] SHORT_FILT = 11'h122,
  parameter logic [SID_W-1:0] SHORT_MASK = 11'h17E,
  parameter logic [EID_W-1:0] LONG_FILT  = 29'h12345678,
  parameter logic [EID_W-1:0] LONG_MASK  = 29'h1FFFFFFF,
  parameter logic [SID_W-1:0] LOCAL_ID   = 11'h456
) (
  input  logic [EID_W-1:0] id,
  input  logic             ext,
  input  logic             rtr,
  output logic             data_ok,
  output logic             remote_ok
);
  logic [SID_W-1:0] s_miss;
  logic [EID_W-1:0] l_miss;

  for (genvar g = 0; g < EID_W; g++) begin : g_long
    assign l_miss[g] = LONG_MASK[g] & (id[g] ^ LONG_FILT[g]);
  end
  for (genvar g = 0; g < SID_W; g++) begin : g_short
    assign s_miss[g] = SHORT_MASK[g] & (id[g] ^ SHORT_FILT[g]);
  end

  logic short_hit, long_hit;
  assign short_hit = ~|s_miss;
  assign long_hit  = ~|l_miss;

  assign data_ok   = !rtr && (ext ? long_hit : short_hit);
  assign remote_ok = rtr && !ext && (id[SID_W-1:0] == LOCAL_ID);
endmodule

// File: rtl/can_rx_burst.sv
module can_rx_burst
  import can_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [DLC_W-1:0]  nbytes,
  input  logic [DATA_W-1:0] data,
  input  logic [EID_W-1:0]  id_in,
  input  logic              ext_in,
  output logic              vld,
  output logic              last,
  output logic [BYTE_W-1:0] byte_o,
  output logic [EID_W-1:0]  id_o,
  output logic              ext_o
);
  logic [DATA_W-1:0] buf_q, aligned;
  logic [DLC_W-1:0]  rem_q;
  logic [CNT_W-1:0]  shamt;

  // the last n bytes shifted in are the payload; move them to the top
  assign shamt   = CNT_W'(DATA_W) - CNT_W'({nbytes, 3'b000});
  assign aligned = data << shamt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= '0; rem_q <= '0; vld <= 1'b0; last <= 1'b0;
      byte_o <= '0; id_o <= '0; ext_o <= 1'b0;
    end else if (go) begin
      vld    <= 1'b1;
      last   <= (nbytes == DLC_W'(1));
      byte_o <= aligned[DATA_W-1 -: BYTE_W];
      buf_q  <= aligned << BYTE_W;
      rem_q  <= nbytes - DLC_W'(1);
      id_o   <= id_in;
      ext_o  <= ext_in;
    end else if (rem_q != '0) begin
      vld    <= 1'b1;
      last   <= (rem_q == DLC_W'(1));
      byte_o <= buf_q[DATA_W-1 -: BYTE_W];
      buf_q  <= buf_q << BYTE_W;
      rem_q  <= rem_q - DLC_W'(1);
    end else begin
      vld  <= 1'b0;
      last <= 1'b0;
    end
  end

  AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> vld); // R5
  AST_ID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !last) |=> (vld && $stable(id_o) && $stable(ext_o))); // R6
endmodule

// File: rtl/can_rx_parser.sv
module can_rx_parser
  import can_rx_pkg::*;
#(
  parameter logic [SID_W-1:0] SHORT_FILT = 11'h122,
  parameter logic [SID_W-1:0] SHORT_MASK = 11'h17E,
  parameter logic [EID_W-1:0] LONG_FILT  = 29'h12345678,
  parameter logic [EID_W-1:0] LONG_MASK  = 29'h1FFFFFFF,
  parameter logic [SID_W-1:0] LOCAL_ID   = 11'h456
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic              bit_vld,
  input  logic              bit_val,
  output logic              ack_req,
  output logic              rx_vld,
  output logic              rx_last,
  output logic [BYTE_W-1:0] rx_byte,
  output logic [EID_W-1:0]  rx_id,
  output logic              rx_ext,
  output logic              remote_req
);
  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [EID_W-1:0]  id_r;
  logic              ext_r, rtr_r;
  logic [2:0]        dlc_r;
  logic [DLC_W-1:0]  nbytes;
  logic [DATA_W-1:0] data_r;

  // named internal events
  logic strobe, crc_en, crc_zero, data_ok, remote_ok, accept, frame_end, burst_go;
  logic [DLC_W-1:0] dlc_full, dlc_nb;

  assign strobe    = bit_vld && !sof;
  assign crc_en    = strobe && (state inside {ST_BASE_ID, ST_B12, ST_IDE, ST_EXT_ID,
                                             ST_RTR, ST_R1, ST_R0, ST_DLC, ST_DATA, ST_CRC});
  assign dlc_full  = {dlc_r, bit_val};
  assign dlc_nb    = dlc_bytes(dlc_full);
  assign accept    = data_ok || remote_ok;
  assign frame_end = strobe && (state == ST_ACK);
  assign burst_go  = frame_end && !rtr_r && (nbytes != '0);
  assign ack_req   = (state == ST_ACK);

  can_rx_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(sof), .en(crc_en), .bit_in(bit_val),
    .crc_zero(crc_zero)
  );

  can_rx_filter #(
    .SHORT_FILT(SHORT_FILT), .SHORT_MASK(SHORT_MASK),
    .LONG_FILT(LONG_FILT), .LONG_MASK(LONG_MASK), .LOCAL_ID(LOCAL_ID)
  ) u_filt (
    .id(id_r), .ext(ext_r), .rtr(rtr_r), .data_ok(data_ok), .remote_ok(remote_ok)
  );

  can_rx_burst u_burst (
    .clk(clk), .rst_n(rst_n), .go(burst_go), .nbytes(nbytes), .data(data_r),
    .id_in(id_r), .ext_in(ext_r), .vld(rx_vld), .last(rx_last),
    .byte_o(rx_byte), .id_o(rx_id), .ext_o(rx_ext)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE; cnt <= '0; id_r <= '0; ext_r <= 1'b0; rtr_r <= 1'b0;
      dlc_r <= '0; nbytes <= '0; data_r <= '0;
    end else if (sof) begin
      state <= ST_BASE_ID;
      cnt   <= CNT_W'(SID_W - 1);
      id_r  <= '0;
      ext_r <= 1'b0;
      rtr_r <= 1'b0;
    end else if (bit_vld) begin
      case (state)
        ST_BASE_ID: begin
          id_r <= {id_r[EID_W-2:0], bit_val};
          if (cnt == '0) state <= ST_B12;
          else cnt <= cnt - CNT_W'(1);
        end
        ST_B12: begin
          rtr_r <= bit_val;
          state <= ST_IDE;
        end
        ST_IDE: begin
          ext_r <= bit_val;
          if (bit_val) begin
            state <= ST_EXT_ID;
            cnt   <= CNT_W'(XID_W - 1);
          end else begin
            state <= ST_R0;
          end
        end
        ST_EXT_ID: begin
          id_r <= {id_r[EID_W-2:0], bit_val};
          if (cnt == '0) state <= ST_RTR;
          else cnt <= cnt - CNT_W'(1);
        end
        ST_RTR: begin
          rtr_r <= bit_val;
          state <= ST_R1;
        end
        ST_R1: state <= ST_R0;
        ST_R0: begin
          state <= ST_DLC;
          cnt   <= CNT_W'(DLC_W - 1);
        end
        ST_DLC: begin
          dlc_r <= dlc_full[2:0];
          if (cnt == '0) begin
            nbytes <= rtr_r ? '0 : dlc_nb;
            if (rtr_r || dlc_nb == '0) begin
              state <= ST_CRC;
              cnt   <= CNT_W'(CRC_W - 1);
            end else begin
              state <= ST_DATA;
              cnt   <= CNT_W'({dlc_nb, 3'b000}) - CNT_W'(1);
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_DATA: begin
          data_r <= {data_r[DATA_W-2:0], bit_val};
          if (cnt == '0) begin
            state <= ST_CRC;
            cnt   <= CNT_W'(CRC_W - 1);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_CRC: begin
          if (cnt == '0) state <= ST_CRC_DEL;
          else cnt <= cnt - CNT_W'(1);
        end
        ST_CRC_DEL: state <= (bit_val && crc_zero && accept) ? ST_ACK : ST_IDLE;
        ST_ACK:     state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) remote_req <= 1'b0;
    else        remote_req <= frame_end && rtr_r;
  end

  AST_ACK_AFTER_DELIM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_req) |-> $past(bit_vld && bit_val)); // R10
  AST_ACK_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && bit_vld && !sof) |=> !ack_req); // R10
  AST_ACK_CRC_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> crc_zero); // R8
  AST_REMOTE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    remote_req |=> !remote_req); // R7
  AST_REMOTE_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    remote_req |-> !rx_vld); // R7
endmodule

// File: tb/sim_can_rx_parser.sv
module sim_can_rx_parser;
  logic clk = 1'b0, rst_n = 1'b0, sof = 1'b0, bit_vld = 1'b0, bit_val = 1'b0;
  logic ack_req, rx_vld, rx_last, rx_ext, remote_req;
  logic [7:0] rx_byte;
  logic [28:0] rx_id;

  always #4 clk = ~clk;

  can_rx_parser u0 (
    .clk(clk), .rst_n(rst_n), .sof(sof), .bit_vld(bit_vld), .bit_val(bit_val),
    .ack_req(ack_req), .rx_vld(rx_vld), .rx_last(rx_last), .rx_byte(rx_byte),
    .rx_id(rx_id), .rx_ext(rx_ext), .remote_req(remote_req)
  );

  int errors = 0, checks = 0;
  logic fb [0:255];
  int nb;

  // monitor state
  logic [7:0] cap [0:15];
  int ncap, nlast, lastpos, idbad, remcnt, ackcyc;
  logic [28:0] exp_id;
  logic exp_ext;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ack_req) ackcyc++;
      if (remote_req) remcnt++;
      if (rx_vld) begin
        if (ncap < 16) cap[ncap] = rx_byte;
        if (rx_last) begin nlast++; lastpos = ncap; end
        if (rx_id !== exp_id || rx_ext !== exp_ext) idbad++;
        ncap++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic b);
    fb[nb] = b;
    nb++;
  endtask

  // remainder by long division with the 16-bit generator
  function automatic logic [14:0] bench_crc(input int n);
    logic [15:0] r;
    r = 16'h0;
    for (int i = -1; i < n + 15; i++) begin
      logic m;
      m = (i < 0 || i >= n) ? 1'b0 : fb[i];
      r = {r[14:0], m};
      if (r[15]) r = r ^ 16'hC599;
    end
    return r[14:0];
  endfunction

  task automatic build(input bit ext, input bit rtr, input logic [28:0] id,
                       input logic [3:0] dlc, input logic [63:0] data,
                       input bit bad_crc, input bit bad_del);
    logic [10:0] base;
    logic [14:0] c;
    int n;
    nb = 0;
    base = ext ? id[28:18] : id[10:0];
    for (int i = 10; i >= 0; i--) push(base[i]);
    if (ext) begin
      push(1'b1); push(1'b1);
      for (int i = 17; i >= 0; i--) push(id[i]);
      push(rtr); push(1'b0); push(1'b0);
    end else begin
      push(rtr); push(1'b0); push(1'b0);
    end
    for (int i = 3; i >= 0; i--) push(dlc[i]);
    n = (dlc > 8) ? 8 : int'(dlc);
    if (!rtr) for (int i = 0; i < n * 8; i++) push(data[63 - i]);
    c = bench_crc(nb);
    if (bad_crc) c[3] = ~c[3];
    for (int i = 14; i >= 0; i--) push(c[i]);
    push(!bad_del);
    for (int i = 0; i < 5; i++) push(1'b1);
  endtask

  task automatic send(input int upto);
    @(negedge clk) sof = 1'b1;
    @(negedge clk) sof = 1'b0;
    for (int i = 0; i < upto; i++) begin
      @(negedge clk); bit_vld = 1'b1; bit_val = fb[i];
      @(negedge clk); bit_vld = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic clear_mon();
    ncap = 0; nlast = 0; lastpos = -1; idbad = 0; remcnt = 0; ackcyc = 0;
  endtask

  task automatic run_frame(input string req, input bit ext, input bit rtr,
                           input logic [28:0] id, input logic [3:0] dlc,
                           input logic [63:0] data, input bit bad_crc, input bit bad_del,
                           input bit exp_ack, input int exp_n, input int exp_rem);
    build(ext, rtr, id, dlc, data, bad_crc, bad_del);
    exp_id = id; exp_ext = ext;
    clear_mon();
    send(nb);
    repeat (12) @(negedge clk);
    chk(ackcyc == (exp_ack ? 3 : 0), {req, " ack cycles"}, ackcyc, exp_ack ? 3 : 0);
    chk(ncap == exp_n, {req, " byte count"}, ncap, exp_n);
    chk(remcnt == exp_rem, {req, " remote pulses"}, remcnt, exp_rem);
    if (exp_n > 0) begin
      chk(nlast == 1 && lastpos == exp_n - 1, {req, " R5 last position"}, lastpos, exp_n - 1);
      chk(idbad == 0, {req, " R6 id held"}, idbad, 0);
      for (int k = 0; k < exp_n; k++)
        chk(cap[k] == data[63 - 8*k -: 8], {req, " R5 byte order"}, cap[k], data[63 - 8*k -: 8]);
    end else begin
      chk(nlast == 0, {req, " no last"}, nlast, 0);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk({ack_req, rx_vld, rx_last, remote_req} == 4'b0, "R1 in reset",
        {ack_req, rx_vld, rx_last, remote_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ack_req, rx_vld, rx_last, remote_req} == 4'b0, "R1 after reset",
        {ack_req, rx_vld, rx_last, remote_req}, 0);
  endtask

  task automatic t_restart();
    build(1'b0, 1'b0, 29'h1A3, 4'd2, 64'hDEAD_0000_0000_0000, 1'b0, 1'b0);
    exp_id = 29'h1A3; exp_ext = 1'b0;
    clear_mon();
    send(20);
    run_frame("R12 restart", 1'b0, 1'b0, 29'h1A3, 4'd2, 64'hBEEF_0000_0000_0000,
              1'b0, 1'b0, 1'b1, 2, 0);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    run_frame("R2 R5 R6 short 0x123", 1'b0, 1'b0, 29'h123, 4'd4,
              64'h1122_3344_0000_0000, 1'b0, 1'b0, 1'b1, 4, 0);
    run_frame("R2 short 0x1A2 one byte", 1'b0, 1'b0, 29'h1A2, 4'd1,
              64'hA500_0000_0000_0000, 1'b0, 1'b0, 1'b1, 1, 0);
    run_frame("R2 R4 short 0x124 rejected", 1'b0, 1'b0, 29'h124, 4'd4,
              64'h1122_3344_0000_0000, 1'b0, 1'b0, 1'b0, 0, 0);
    run_frame("R3 R5 R6 long match", 1'b1, 1'b0, 29'h12345678, 4'd8,
              64'h0102_0304_0506_0708, 1'b0, 1'b0, 1'b1, 8, 0);
    run_frame("R3 R4 long miss", 1'b1, 1'b0, 29'h12345679, 4'd3,
              64'hAABB_CC00_0000_0000, 1'b0, 1'b0, 1'b0, 0, 0);
    run_frame("R7 remote local", 1'b0, 1'b1, 29'h456, 4'd4,
              64'h0, 1'b0, 1'b0, 1'b1, 0, 1);
    run_frame("R7 remote foreign", 1'b0, 1'b1, 29'h123, 4'd4,
              64'h0, 1'b0, 1'b0, 1'b0, 0, 0);
    run_frame("R8 bad crc", 1'b0, 1'b0, 29'h123, 4'd2,
              64'h5A5A_0000_0000_0000, 1'b1, 1'b0, 1'b0, 0, 0);
    run_frame("R9 dlc 15", 1'b0, 1'b0, 29'h122, 4'd15,
              64'hF0E1_D2C3_B4A5_9687, 1'b0, 1'b0, 1'b1, 8, 0);
    run_frame("R11 zero length", 1'b0, 1'b0, 29'h123, 4'd0,
              64'h0, 1'b0, 1'b0, 1'b1, 0, 0);
    run_frame("R10 dominant delimiter", 1'b0, 1'b0, 29'h123, 4'd1,
              64'h7700_0000_0000_0000, 1'b0, 1'b1, 1'b0, 0, 0);
    t_restart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule